// File: doc/BRIEF.md
# Programmable Sample-Clock Divider

This block turns one fixed base clock into the clock enable for an ADPCM decoder and into the sample-rate tick that follows from it. Software writes a small divider code through a single write strobe. The block then produces a one-cycle enable at the base rate divided by a ratio of sixteen minus that code. So the decoder's converter clock, and with it the playback sample rate, can take one of sixteen values. A second counter divides that enable by a further 48 and marks each sample period.

Both outputs are enables in the base clock domain. Downstream logic gates its flops with them rather than using them as clocks. A code written while a period is under way is held until the current period ends. Each period therefore runs with exactly one ratio. With a base clock of about 1.54 MHz, code 12 yields a sample tick near 8.02 kHz and code 15 one near 32.09 kHz.

Top module: `xt_rate_divider`

## Requirements
- R1: A write (`wr_en` high at a clock edge) stores bits [3:0] of `wr_data` as the divider code, and bits [7:4] have no effect on any output.
- R2: The number of base clock cycles from one `xt_en` pulse to the next equals 16 minus the code in force for that period, giving ratios from 16 (code 0) down to 1 (code 15).
- R3: With code 15 in force, `xt_en` is high on every base clock cycle.
- R4: `smp_tick` is high only in a cycle where `xt_en` is high, and it is high on exactly every 48th `xt_en` pulse counted from reset.
- R5: With a steady code, `smp_tick` pulses occur every 48 × (16 − code) base cycles: every 192 cycles for code 12 and every 48 cycles for code 15.
- R6: A code written during a period takes effect at the next `xt_en` pulse. The period in progress keeps its old ratio. A write in the same cycle as an `xt_en` pulse governs the period that starts right after that pulse.
- R7: While `rst_n` is low both outputs are low. After reset the code is 0 and both counters are cleared, so the first `xt_en` comes 16 cycles after reset is released and the first `smp_tick` comes with the 48th `xt_en`.
- R8: `smp_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Divider register write strobe |
| wr_data | input | 8 | Write data; only bits [3:0] are used |
| xt_en | output | 1 | One-cycle decoder clock enable at base / (16 − code) |
| smp_tick | output | 1 | One-cycle sample-rate tick, every 48th `xt_en` |

## Verification
The assertions assume that `wr_en` and `wr_data` are synchronous to `clk` and settle well before each rising edge, and that `rst_n` is only ever released clear of an edge. The stimulus meets both conditions: every input, reset included, changes one nanosecond after a rising edge, and outputs are sampled on the falling edge. The write strobe may arrive on any cycle, including one with an `xt_en` pulse, and the random phase places writes at random offsets within periods so that both cases occur. The reference model in the bench follows the code latched at each pulse and the running count of pulses.

// File: rtl/xtdiv_pkg.sv
package xtdiv_pkg;

    // Default geometry of the divider
    localparam int unsigned DEF_CODE_W   = 4;
    localparam int unsigned DEF_DATA_W   = 8;
    localparam int unsigned DEF_TICK_DIV = 48;

    // Ratio selected by a code: full scale minus the code
    function automatic int unsigned ratio_of(input int unsigned code,
                                             input int unsigned code_w);
        return (1 << code_w) - code;
    endfunction

endpackage

// File: rtl/xtdiv_code_reg.sv
module xtdiv_code_reg #(
    parameter int unsigned CODE_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              boundary,
    output logic [CODE_W:0]   ratio
);
    localparam int unsigned RATIO_W = CODE_W + 1;
    localparam logic [RATIO_W-1:0] RATIO_FULL = RATIO_W'(1 << CODE_W);

    typedef struct packed {
        logic [CODE_W-1:0] pend;   // last written code
        logic [CODE_W-1:0] live;   // code governing the running period
    } code_state_t;

    code_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.pend = wr_data[CODE_W-1:0];
        end
        if (boundary) begin
            st_d.live = st_d.pend;   // a same-cycle write is taken at once
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio = RATIO_FULL - {1'b0, st_q.live};

endmodule

// File: rtl/xtdiv_xt_counter.sv
module xtdiv_xt_counter #(
    parameter int unsigned CODE_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CODE_W:0] ratio,
    output logic            xt_en
);
    localparam int unsigned RATIO_W = CODE_W + 1;

    typedef struct packed {
        logic [CODE_W-1:0] cnt;
    } xt_state_t;

    xt_state_t st_d, st_q;
    logic [RATIO_W-1:0] last_val;

    always_comb begin
        last_val = ratio - RATIO_W'(1);
        xt_en    = ({1'b0, st_q.cnt} == last_val);
        st_d     = st_q;
        if (xt_en) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CODE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/xtdiv_tick_counter.sv
module xtdiv_tick_counter #(
    parameter int unsigned TICK_DIV = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xt_en,
    output logic tick
);
    generate
        if (TICK_DIV <= 1) begin : g_pass
            assign tick = xt_en;
        end else begin : g_count
            localparam int unsigned CNT_W = $clog2(TICK_DIV);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

            typedef struct packed {
                logic [CNT_W-1:0] cnt;
            } tick_state_t;

            tick_state_t st_d, st_q;

            always_comb begin
                tick = xt_en && (st_q.cnt == LAST);
                st_d = st_q;
                if (xt_en) begin
                    st_d.cnt = tick ? '0 : st_q.cnt + CNT_W'(1);
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/xt_rate_divider.sv
module xt_rate_divider #(
    parameter int unsigned CODE_W   = xtdiv_pkg::DEF_CODE_W,
    parameter int unsigned DATA_W   = xtdiv_pkg::DEF_DATA_W,
    parameter int unsigned TICK_DIV = xtdiv_pkg::DEF_TICK_DIV
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              xt_en,
    output logic              smp_tick
);
    logic [CODE_W:0] ratio;

    xtdiv_code_reg #(.CODE_W(CODE_W), .DATA_W(DATA_W)) i_code (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .boundary (xt_en),
        .ratio    (ratio)
    );

    xtdiv_xt_counter #(.CODE_W(CODE_W)) i_xt (
        .clk   (clk),
        .rst_n (rst_n),
        .ratio (ratio),
        .xt_en (xt_en)
    );

    xtdiv_tick_counter #(.TICK_DIV(TICK_DIV)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .xt_en (xt_en),
        .tick  (smp_tick)
    );

endmodule

// File: rtl/xt_rate_divider_chk.sv
module xt_rate_divider_chk #(
    parameter int unsigned CODE_W   = 4,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned TICK_DIV = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              xt_en,
    input logic              smp_tick
);
    localparam int unsigned GAP_W = CODE_W + 1;
    localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(1 << CODE_W);
    localparam int unsigned NUM_W = $clog2(TICK_DIV + 1);

    logic [GAP_W-1:0] gap_q;   // cycles since the last xt_en
    logic [NUM_W-1:0] num_q;   // xt_en pulses modulo TICK_DIV

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
            num_q <= '0;
        end else begin
            gap_q <= xt_en ? '0 : gap_q + GAP_W'(1);
            if (xt_en) begin
                num_q <= (num_q == NUM_W'(TICK_DIV - 1)) ? '0 : num_q + NUM_W'(1);
            end
        end
    end

    // R2 / R7: no period is longer than the largest ratio
    a_r2_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        xt_en |-> (gap_q < GAP_LIM));

    // R3: the all-ones code taken at a boundary keeps the enable high
    a_r3_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (xt_en && wr_en && (wr_data[CODE_W-1:0] == {CODE_W{1'b1}})) |=> xt_en);

    // R4: the sample tick rides on an xt enable
    a_r4_tick_on_xt: assert property (@(posedge clk) disable iff (!rst_n)
        smp_tick |-> xt_en);

    // R4: the tick marks every TICK_DIV-th enable
    a_r4_tick_count: assert property (@(posedge clk) disable iff (!rst_n)
        xt_en |-> (smp_tick == (num_q == NUM_W'(TICK_DIV - 1))));

    // R8: the tick lasts one cycle
    a_r8_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        smp_tick |=> !smp_tick);

endmodule

bind xt_rate_divider xt_rate_divider_chk #(
    .CODE_W(CODE_W), .DATA_W(DATA_W), .TICK_DIV(TICK_DIV)
) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .xt_en(xt_en), .smp_tick(smp_tick)
);

// File: tb/test_xt_rate_divider.sv
`timescale 1ns/1ps
module test_xt_rate_divider;
    localparam int TICKS = 48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       xt_en, smp_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int steady_ratio = 0;

    always #2 clk = ~clk;   // 250 MHz

    xt_rate_divider i_xt_rate_divider (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .xt_en(xt_en), .smp_tick(smp_tick)
    );

    function automatic int ratio_for(input logic [3:0] code);
        return 16 - int'(code);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model, sampled on falling edges
    logic [3:0] pend = '0;
    int exp_r = 16, gap = 0, xt_num = 0, tgap = 0;
    bit tvalid = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            pend = '0; exp_r = 16; gap = 0; xt_num = 0; tgap = 0; tvalid = 1'b0;
        end else begin
            gap++;
            tgap++;
            if (xt_en) begin
                check(gap == exp_r, (exp_r == 1) ? "R3" : "R2/R6/R1/R7", gap, exp_r);
                gap = 0;
                xt_num++;
                check(smp_tick == ((xt_num % TICKS) == 0), "R4", int'(smp_tick),
                      int'((xt_num % TICKS) == 0));
                exp_r = ratio_for(wr_en ? wr_data[3:0] : pend);
            end else if (smp_tick) begin
                check(1'b0, "R4/R8", 1, 0);
            end
            if (smp_tick) begin
                if (steady_ratio != 0 && tvalid)
                    check(tgap == TICKS * steady_ratio, "R5", tgap, TICKS * steady_ratio);
                tvalid = (steady_ratio != 0);
                tgap = 0;
            end
            if (steady_ratio == 0) tvalid = 1'b0;
            if (wr_en) pend = wr_data[3:0];
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wr_en = 1'b0;
        end
    endtask

    task automatic write(input logic [7:0] v);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd12345));
        // R7: outputs quiet in reset
        repeat (3) @(posedge clk);
        #1;
        check(xt_en == 1'b0, "R7", int'(xt_en), 0);
        check(smp_tick == 1'b0, "R7", int'(smp_tick), 0);
        rst_n = 1'b1;
        cycles(16 * TICKS + 40);   // default ratio 16 and first tick (R7)

        // R1: upper bits ignored, 0xF3 gives ratio 13
        write(8'hF3);
        cycles(200);
        write(8'h5C);              // code 12 with junk in upper bits
        cycles(2 * 16 * TICKS);
        steady_ratio = 4;          // R5: 192-cycle tick
        cycles(192 * 4 + 8);
        steady_ratio = 0;
        write(8'h0F);              // R3: code 15
        cycles(16 * TICKS + 20);
        steady_ratio = 1;          // R5: 48-cycle tick
        cycles(48 * 5 + 4);
        steady_ratio = 0;

        // Random writes at random offsets (R6)
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk); #1;
            if ($urandom_range(29) == 0) begin
                wr_en = 1'b1;
                wr_data = 8'($urandom);
            end else begin
                wr_en = 1'b0;
            end
        end
        cycles(4);

        // R7: a second reset restores the default ratio
        rst_n = 1'b0;
        cycles(2);
        check(xt_en == 1'b0 && smp_tick == 1'b0, "R7", int'(xt_en | smp_tick), 0);
        rst_n = 1'b1;
        cycles(16 * TICKS + 20);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule